// File: doc/BRIEF.md
# Counter Event Flag and Routing Controller

This block sits beside two 8-bit counters and a timer. It raises two sticky interrupt flags from the counting activity of those counters. Flag 3 watches counter 1 and flag 4 watches counter 2. Each flag has its own 2-bit trigger mode. The modes are: every count event, a new count value that is a multiple of 4, a new count value that is a multiple of 64, or a terminal transition. The terminal transition differs per counter. Counter 1 fires on an upward wrap from FFh to 00h. Counter 2 fires on a downward step from 01h to 00h.

The block also drives the two timer capture inputs. With routing off, capture input 1 follows the external excitation signal and capture input 2 follows the comparator output. With routing on, each capture input follows one of four status bits, picked by its own 2-bit selector.

Software reaches the block through one 16-bit register port with two addresses. Address 0 is the control word. Address 1 is the flag word, which clears flags on write-one and can also force them set for test.

Top module: `cnt_flag_router`

## Requirements
- R1: After reset, the control bits [15:7] read as 0, and flag3_out and flag4_out are 0.
- R2: In the control word (reg_addr=0), bits [15:7] are read/write. Bits [6:4] read 0. Bits [3:0] read the live stat_in value, and writes to bits [6:0] are ignored. Reads are combinational.
- R3: With control bit 7 = 0, cap1_out equals exc_in and cap2_out equals cmp_in.
- R4: With control bit 7 = 1, cap1_out equals stat_in[ctrl[13:12]] and cap2_out equals stat_in[ctrl[15:14]], where codes 00/01/10/11 pick status bits 0/1/2/3.
- R5: Trigger code 00 (flag 3 mode in ctrl[9:8], flag 4 mode in ctrl[11:10]) sets the flag on every count event, up or down.
- R6: Trigger code 01 sets the flag only in a cycle with a count event whose new value (the cN_val of that cycle) is a multiple of 4. A counter that holds at such a value does not set the flag again.
- R7: Trigger code 10 sets the flag only on a count event whose new value is a multiple of 64.
- R8: Trigger code 11 sets flag 3 only on an upward count event where counter 1 goes from FFh to 00h. A downward step from 00h to FFh does not set it.
- R9: Trigger code 11 sets flag 4 only on a downward count event where counter 2 goes from 01h to 00h. An upward wrap from FFh to 00h does not set it.
- R10: Flags are sticky. Writing the flag word (reg_addr=1) with bit 0 = 1 clears flag 3, and with bit 1 = 1 clears flag 4. The flag word reads {14'b0, flag4, flag3}.
- R11: In a flag-word write, bit 8 = 1 sets flag 3 and bit 9 = 1 sets flag 4. A set, whether from software or from a trigger, wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control word, 1 = flag word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| c1_evt | input | 1 | Counter 1 counted this cycle |
| c1_up | input | 1 | Counter 1 direction (1 = up) |
| c1_val | input | 8 | Counter 1 value (new value on an event cycle) |
| c2_evt | input | 1 | Counter 2 counted this cycle |
| c2_up | input | 1 | Counter 2 direction (1 = up) |
| c2_val | input | 8 | Counter 2 value (new value on an event cycle) |
| stat_in | input | 4 | Status output bits |
| exc_in | input | 1 | External excitation signal |
| cmp_in | input | 1 | Comparator output |
| cap1_out | output | 1 | Capture input 1 |
| cap2_out | output | 1 | Capture input 2 |
| flag3_out | output | 1 | Sticky flag from counter 1 |
| flag4_out | output | 1 | Sticky flag from counter 2 |

## Verification
The bench holds a counter at a multiple of 4 with no events. A design that tested the value level instead of the event would then keep re-raising the flag after software clears it. It walks each counter across 00h in both directions. A terminal detector that ignored direction would fire flag 3 on a 00h to FFh step, or flag 4 on an FFh to 00h wrap. It writes set and clear together in one flag-word write, where a wrong priority leaves the flag low. Random walks of both counters, mixed with random register writes, check the routing and all trigger modes against a bench model.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  typedef enum logic [1:0] {
    TRG_EVERY = 2'b00,
    TRG_MODA  = 2'b01,
    TRG_MODB  = 2'b10,
    TRG_TERM  = 2'b11
  } trig_mode_t;

  localparam int unsigned REG_W    = 16;
  localparam int unsigned NSTAT    = 4;
  localparam int unsigned SEL_W    = $clog2(NSTAT);
  localparam int unsigned CTRL_LSB = 7;
  // control field positions
  localparam int unsigned ROUTE_BIT = 7;
  localparam int unsigned TRG3_LSB  = 8;
  localparam int unsigned TRG4_LSB  = 10;
  localparam int unsigned SEL1_LSB  = 12;
  localparam int unsigned SEL2_LSB  = 14;
  // flag word positions
  localparam int unsigned CLR_LSB   = 0;
  localparam int unsigned SET_LSB   = 8;
endpackage

// File: rtl/cfr_trigger.sv
module cfr_trigger
  import cfr_pkg::*;
#(
  parameter int unsigned CW        = 8,
  parameter int unsigned MODA_BITS = 2,
  parameter int unsigned MODB_BITS = 6,
  parameter bit          TERM_UP   = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic          up,
  input  logic [CW-1:0] val,
  input  trig_mode_t    mode,
  output logic          hit
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] prev_q;
  logic every_hit, moda_hit, modb_hit, term_hit;

  function automatic logic is_multiple(input logic [CW-1:0] v, input int unsigned bits);
    logic [CW-1:0] mask;
    mask = {CW{1'b1}} >> (CW - bits);
    return (v & mask) == '0;
  endfunction

  function automatic logic is_terminal(input logic [CW-1:0] pv, input logic [CW-1:0] nv,
                                       input logic dir_up);
    if (TERM_UP) return dir_up && (pv == {CW{1'b1}}) && (nv == '0);
    else         return !dir_up && (pv == ONE) && (nv == '0);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= val;
  end

  assign every_hit = evt;
  assign moda_hit  = evt && is_multiple(val, MODA_BITS);
  assign modb_hit  = evt && is_multiple(val, MODB_BITS);
  assign term_hit  = evt && is_terminal(prev_q, val, up);

  always_comb begin
    unique case (mode)
      TRG_EVERY: hit = every_hit;
      TRG_MODA:  hit = moda_hit;
      TRG_MODB:  hit = modb_hit;
      default:   hit = term_hit;
    endcase
  end

  // R6: a level condition alone never sets a flag
  a_r6_hit_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> evt);
  // R7: every multiple of 64 is also a multiple of 4
  a_r7_modb_in_moda: assert property (@(posedge clk) disable iff (!rst_n)
    modb_hit |-> moda_hit);
  // R8/R9: terminal hit only in the counter's own direction
  a_r9_term_direction: assert property (@(posedge clk) disable iff (!rst_n)
    term_hit |-> (up == TERM_UP));
endmodule

// File: rtl/cfr_route.sv
module cfr_route
  import cfr_pkg::*;
(
  input  logic [NSTAT-1:0]            stat,
  input  logic                        route_en,
  input  logic [1:0][SEL_W-1:0]       sel,
  input  logic [1:0]                  alt,
  output logic [1:0]                  cap
);
  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic picked;
    assign picked = stat[sel[g]];
    assign cap[g] = route_en ? picked : alt[g];
  end
endmodule

// File: rtl/cfr_flag.sv
module cfr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_set,
  input  logic clr,
  output logic flag
);
  logic set_any;
  assign set_any = hw_set | sw_set;

  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_any) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

  // R11: set request wins over a same-cycle clear
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set |=> flag);
  // R10: sticky until cleared
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R10: a clear with no set drops the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hw_set && !sw_set) |=> !flag);
endmodule

// File: rtl/cnt_flag_router.sv
module cnt_flag_router
  import cfr_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             c1_evt,
  input  logic             c1_up,
  input  logic [CW-1:0]    c1_val,
  input  logic             c2_evt,
  input  logic             c2_up,
  input  logic [CW-1:0]    c2_val,
  input  logic [NSTAT-1:0] stat_in,
  input  logic             exc_in,
  input  logic             cmp_in,
  output logic             cap1_out,
  output logic             cap2_out,
  output logic             flag3_out,
  output logic             flag4_out
);
  localparam int unsigned CTRL_W = REG_W - CTRL_LSB;

  logic [CTRL_W-1:0] ctrl_q;
  logic [REG_W-1:0]  ctrl_word;
  logic              wr_ctrl, wr_flag;

  assign wr_ctrl   = reg_we && !reg_addr;
  assign wr_flag   = reg_we && reg_addr;
  assign ctrl_word = {ctrl_q, {(CTRL_LSB - NSTAT){1'b0}}, stat_in};

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= reg_wdata[REG_W-1:CTRL_LSB];
  end

  // per-counter channel arrays
  logic [1:0]         evt, up, hit, flag, sw_set, clr;
  logic [1:0][CW-1:0] val;
  trig_mode_t [1:0]   mode;

  assign evt  = {c2_evt, c1_evt};
  assign up   = {c2_up, c1_up};
  assign val  = {c2_val, c1_val};
  assign mode = {trig_mode_t'(ctrl_word[TRG4_LSB +: 2]), trig_mode_t'(ctrl_word[TRG3_LSB +: 2])};

  for (genvar i = 0; i < 2; i++) begin : g_cnt
    cfr_trigger #(
      .CW(CW), .MODA_BITS(2), .MODB_BITS(6), .TERM_UP(i == 0)
    ) u_trig (
      .clk(clk), .rst_n(rst_n), .evt(evt[i]), .up(up[i]), .val(val[i]),
      .mode(mode[i]), .hit(hit[i])
    );
    assign sw_set[i] = wr_flag && reg_wdata[SET_LSB + i];
    assign clr[i]    = wr_flag && reg_wdata[CLR_LSB + i];
    cfr_flag u_flag (
      .clk(clk), .rst_n(rst_n), .hw_set(hit[i]), .sw_set(sw_set[i]),
      .clr(clr[i]), .flag(flag[i])
    );
  end

  assign flag3_out = flag[0];
  assign flag4_out = flag[1];

  logic [1:0]            cap;
  logic [1:0][SEL_W-1:0] sel;
  assign sel = {ctrl_word[SEL2_LSB +: SEL_W], ctrl_word[SEL1_LSB +: SEL_W]};

  cfr_route u_route (
    .stat(stat_in), .route_en(ctrl_word[ROUTE_BIT]), .sel(sel),
    .alt({cmp_in, exc_in}), .cap(cap)
  );
  assign cap1_out = cap[0];
  assign cap2_out = cap[1];

  assign reg_rdata = reg_addr ? {{(REG_W-2){1'b0}}, flag4_out, flag3_out} : ctrl_word;

  // R2: control bits change only through a control-word write
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));
  // R8: flag 3 in terminal mode rises only after an upward event
  a_r8_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] == TRG_TERM && !sw_set[0] && !flag3_out && !c1_up) |=> !flag3_out);
endmodule

// File: tb/cnt_flag_router_bench.sv
`timescale 1ns/1ps
module cnt_flag_router_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, reg_we, reg_addr, c1_evt, c1_up, c2_evt, c2_up, exc_in, cmp_in;
  logic [15:0] reg_wdata, reg_rdata;
  logic [7:0] c1_val, c2_val;
  logic [3:0] stat_in;
  logic cap1_out, cap2_out, flag3_out, flag4_out;

  cnt_flag_router u_cnt_flag_router (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] m_ctrl;
  logic m_f3, m_f4;
  logic [7:0] v1, v2;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit trig(logic [1:0] md, bit e, bit u, logic [7:0] pv, logic [7:0] nv, bit first);
    case (md)
      2'd0: return e;
      2'd1: return e && (nv % 4 == 0);
      2'd2: return e && (nv % 64 == 0);
      default: return e && (first ? (u && pv == 8'hFF && nv == 8'h00)
                                  : (!u && pv == 8'h01 && nv == 8'h00));
    endcase
  endfunction

  function automatic string ftag(bit s, bit c, logic [1:0] md, bit first);
    if (s) return "R11";
    if (c) return "R10";
    case (md)
      2'd0: return "R5";
      2'd1: return "R6";
      2'd2: return "R7";
      default: return first ? "R8" : "R9";
    endcase
  endfunction

  // one clock: entered and left just after a falling edge
  task automatic cyc(bit we, bit a, logic [15:0] wd, bit e1, bit u1, bit e2, bit u2,
                     logic [3:0] st, bit ex, bit cm);
    logic [7:0] n1, n2;
    bit h3, h4, s3, s4, c3, c4;
    n1 = e1 ? (u1 ? v1 + 8'd1 : v1 - 8'd1) : v1;
    n2 = e2 ? (u2 ? v2 + 8'd1 : v2 - 8'd1) : v2;
    reg_we = we; reg_addr = a; reg_wdata = wd;
    c1_evt = e1; c1_up = u1; c1_val = n1;
    c2_evt = e2; c2_up = u2; c2_val = n2;
    stat_in = st; exc_in = ex; cmp_in = cm;
    #1;
    if (a) chk("R10 flag read", reg_rdata, {14'b0, m_f4, m_f3});
    else   chk("R2 ctrl read", reg_rdata, m_ctrl | {12'b0, st});
    if (m_ctrl[7]) begin
      chk("R4 cap1", cap1_out, st[m_ctrl[13:12]]);
      chk("R4 cap2", cap2_out, st[m_ctrl[15:14]]);
    end else begin
      chk("R3 cap1", cap1_out, ex);
      chk("R3 cap2", cap2_out, cm);
    end
    h3 = trig(m_ctrl[9:8], e1, u1, v1, n1, 1'b1);
    h4 = trig(m_ctrl[11:10], e2, u2, v2, n2, 1'b0);
    s3 = we && a && wd[8];  s4 = we && a && wd[9];
    c3 = we && a && wd[0];  c4 = we && a && wd[1];
    @(posedge clk); #1;
    m_f3 = (h3 || s3) ? 1'b1 : (c3 ? 1'b0 : m_f3);
    m_f4 = (h4 || s4) ? 1'b1 : (c4 ? 1'b0 : m_f4);
    if (we && !a) m_ctrl = wd & 16'hFF80;
    v1 = n1; v2 = n2;
    chk(ftag(s3, c3, m_ctrl[9:8], 1'b1), flag3_out, m_f3);
    chk(ftag(s4, c4, m_ctrl[11:10], 1'b0), flag4_out, m_f4);
    @(negedge clk);
  endtask

  task automatic idle(int n); for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 4'h5, 0, 1); endtask
  task automatic wr(bit a, logic [15:0] d); cyc(1, a, d, 0, 0, 0, 0, 4'h9, 1, 0); endtask
  task automatic step1(bit u); cyc(0, 1, 0, 1, u, 0, 0, 4'h3, 0, 0); endtask
  task automatic step2(bit u); cyc(0, 1, 0, 0, 0, 1, u, 4'hC, 1, 1); endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0005EED7));
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    c1_evt = 0; c1_up = 0; c1_val = 0; c2_evt = 0; c2_up = 0; c2_val = 0;
    stat_in = 4'hA; exc_in = 0; cmp_in = 0;
    m_ctrl = 0; m_f3 = 0; m_f4 = 0; v1 = 0; v2 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 ctrl reset", reg_rdata, 16'h000A);
    chk("R1 flag3 reset", flag3_out, 0);
    chk("R1 flag4 reset", flag4_out, 0);
    @(negedge clk);
    // R2: writable and ignored bits
    wr(0, 16'hFFFF); idle(2);
    // R4 routing with each selector
    for (int s = 0; s < 4; s++) begin
      wr(0, 16'h0080 | 16'(s << 12) | 16'(((s + 1) % 4) << 14));
      for (int p = 0; p < 4; p++) cyc(0, 0, 0, 0, 0, 0, 0, 4'(1 << p), 0, 0);
    end
    wr(0, 16'h0000); idle(2);                      // R3
    // R6: count to 4, then hold there with no events
    wr(1, 16'h0003); wr(0, 16'h0100);
    for (int k = 0; k < 4; k++) step1(1);
    wr(1, 16'h0001); idle(5);
    // R8: down across zero must not fire, up wrap must
    wr(0, 16'h0300);
    for (int k = 0; k < 5; k++) step1(0);
    step1(1);
    // R9: up-wrap must not fire, decrement 01->00 must
    wr(1, 16'h0003); wr(0, 16'h0C00);
    step2(1); step2(0); wr(1, 16'h0002);
    step2(0); step2(1);
    // R7: mod-64 on counter 2 walking up
    wr(1, 16'h0003); wr(0, 16'h0800);
    for (int k = 0; k < 70; k++) step2(1);
    // R11: set and clear in one write
    wr(1, 16'h0303); wr(1, 16'h0003); wr(1, 16'h0100);
    // random mix
    for (int k = 0; k < 4000; k++) begin
      bit we;
      we = ($urandom % 16) == 0;
      cyc(we, 1'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule